// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Controller

This block sits on the synchronous side of a chip and turns single-beat read and write requests into the timed strobe sequences that an external asynchronous static RAM of 512K bytes expects. A requester presents a 19-bit address, an 8-bit write value and a direction bit with a valid flag. The controller takes the request when it is idle and, once the sequence has finished, raises a one-cycle completion pulse. For a read, the fetched byte is available alongside that pulse.

On the memory side the controller drives the address, active-low chip select, read strobe and write strobe, all from registers. The data bus is split into an outgoing byte, an incoming byte and a drive-enable bit, so a pad ring can build the tri-state buffer. Each strobe phase is a whole number of clock cycles. The phase lengths are computed at elaboration from the clock period and the memory's minimum times, and are rounded up, so a single parameter set retargets the block to a new clock.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: While reset is asserted and after it is released with no request, mem_ce_n, mem_oe_n and mem_we_n are 1 and mem_dq_oe and req_ready are 0.
- R2: A read drives mem_ce_n=0 and mem_we_n=1. mem_oe_n is 0 only during the read wait phase, and mem_addr holds the requested address for the whole read.
- R3: Take the accepting clock edge as edge 0. For a read, req_ready is 1 after edge 1+RD_CYC and 0 again after the next edge. RD_CYC is the address access time divided by the clock period and rounded up, with a minimum of 1; the default is 3, giving a latency of 4.
- R4: The rsp_rdata value shown with req_ready for a read is the byte on mem_dq_i at the last edge of the read wait phase. It stays unchanged until the next read completes.
- R5: During a write, mem_we_n is low for exactly WP_CYC consecutive cycles, where WP_CYC = max(ceil(write pulse/clock), ceil(data setup/clock)+1, 1); the default is 3. mem_ce_n is 0 and mem_oe_n is 1 whenever mem_we_n is 0, and mem_addr does not change while mem_we_n is 0.
- R6: mem_dq_oe is 1 only while mem_we_n is 0 and mem_oe_n is 1. It turns on one cycle after mem_we_n falls, drops at the same edge where mem_we_n rises, and stays on for WP_CYC-1 cycles, which covers the data setup time.
- R7: For a write, req_ready is 1 after edge SU_CYC+WP_CYC+REC_CYC and for one cycle only. SU_CYC is the output-float time rounded up (default 2), and REC_CYC tops up the write cycle time with a minimum of 1 (default 1), giving a default latency of 6.
- R8: req_valid is ignored while a sequence is in progress. A second request held during a write produces neither a second req_ready pulse nor a memory write.
- R9: A byte written through the controller reads back unchanged at every address from 0 to 7FFFF hex, and each write touches only its own address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present; sampled only when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address of the request |
| req_wdata | input | 8 | Byte to write |
| req_ready | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Byte from the last completed read |
| mem_addr | output | 19 | Memory address, registered |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory read strobe, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_dq_o | output | 8 | Byte driven onto the memory bus |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_o |
| mem_dq_i | input | 8 | Byte read from the memory bus |

## Verification
The bench's memory model returns garbage until the read strobe has been low for the output-enable access time. A controller that samples one cycle early therefore reads back a wrong byte. The model also latches data only on the rising write strobe, and only if the drive enable was on just before it. A write pulse that is one cycle too short, or a drive window that opens late, shows up as a wrong pulse length or as lost data. The model also flags bus contention and any address change under a low write strobe. The sweep writes walking-one addresses, both address extremes and a run of neighbouring addresses, and then reads all of them back, so a fault that merges address bits or corrupts neighbouring locations is caught. A second request held high through a busy write checks that it is neither accepted nor acknowledged.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE       = 3'd0,
    ST_RD_SETUP   = 3'd1,
    ST_RD_WAIT    = 3'd2,
    ST_WR_SETUP   = 3'd3,
    ST_WR_PULSE   = 3'd4,
    ST_WR_RECOVER = 3'd5
  } seq_state_e;

  // Minimum time in picoseconds -> whole clock cycles, at least one.
  function automatic int unsigned ceil_cyc(input int unsigned t_ps, input int unsigned clk_ps);
    int unsigned c;
    c = (t_ps + clk_ps - 1) / clk_ps;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned RD_CYC  = 3,
  parameter int unsigned SU_CYC  = 2,
  parameter int unsigned WP_CYC  = 3,
  parameter int unsigned REC_CYC = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       req_write,
  output seq_state_e state_q,
  output seq_state_e state_d,
  output logic       accept,
  output logic       finish
);

  localparam int unsigned MAX_LEN = max_u(max_u(RD_CYC, SU_CYC), max_u(WP_CYC, REC_CYC));
  localparam int unsigned CNT_W   = (MAX_LEN < 2) ? 1 : $clog2(MAX_LEN);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  function automatic logic [CNT_W-1:0] phase_len(input seq_state_e s);
    case (s)
      ST_RD_WAIT:    return CNT_W'(RD_CYC - 1);
      ST_WR_SETUP:   return CNT_W'(SU_CYC - 1);
      ST_WR_PULSE:   return CNT_W'(WP_CYC - 1);
      ST_WR_RECOVER: return CNT_W'(REC_CYC - 1);
      default:       return '0;
    endcase
  endfunction

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:       if (req_valid) state_d = req_write ? ST_WR_SETUP : ST_RD_SETUP;
      ST_RD_SETUP:   state_d = ST_RD_WAIT;
      ST_RD_WAIT:    if (cnt_zero) state_d = ST_IDLE;
      ST_WR_SETUP:   if (cnt_zero) state_d = ST_WR_PULSE;
      ST_WR_PULSE:   if (cnt_zero) state_d = ST_WR_RECOVER;
      ST_WR_RECOVER: if (cnt_zero) state_d = ST_IDLE;
      default:       state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    if (state_d != state_q)  cnt_d = phase_len(state_d);
    else if (!cnt_zero)      cnt_d = cnt_q - 1'b1;
    else                     cnt_d = cnt_q;
  end

  assign accept = (state_q == ST_IDLE) && req_valid;
  assign finish = (state_q != ST_IDLE) && (state_d == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  // A busy controller never re-enters a start phase without passing idle.
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && state_q != ST_RD_SETUP && state_q != ST_WR_SETUP && state_q != ST_RD_WAIT)
      |=> (state_q != ST_RD_SETUP)); // R8

  AST_PULSE_FROM_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WR_PULSE && $past(state_q) != ST_WR_PULSE) |-> $past(state_q) == ST_WR_SETUP); // R5

endmodule

// File: rtl/sram_pin_regs.sv
module sram_pin_regs
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_state_e        state_q,
  input  seq_state_e        state_d,
  input  logic              accept,
  input  logic              finish,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              req_ready
);

  logic ce_n_d, oe_n_d, we_n_d, dq_oe_d, capture_en;

  always_comb begin
    ce_n_d  = !(state_d == ST_RD_SETUP || state_d == ST_RD_WAIT ||
                state_d == ST_WR_SETUP || state_d == ST_WR_PULSE);
    oe_n_d  = !(state_d == ST_RD_WAIT);
    we_n_d  = !(state_d == ST_WR_PULSE);
    // Drive opens one cycle into the pulse and closes with the rising strobe.
    dq_oe_d = (state_d == ST_WR_PULSE) && (state_q == ST_WR_PULSE);
    capture_en = finish && (state_q == ST_RD_WAIT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ce_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
      req_ready <= 1'b0;
    end else begin
      mem_ce_n  <= ce_n_d;
      mem_oe_n  <= oe_n_d;
      mem_we_n  <= we_n_d;
      mem_dq_oe <= dq_oe_d;
      req_ready <= finish;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr <= '0;
      mem_dq_o <= '0;
    end else if (accept) begin
      mem_addr <= req_addr;
      mem_dq_o <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rsp_rdata <= '0;
    else if (capture_en) rsp_rdata <= mem_dq_i;
  end

  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (mem_oe_n && !mem_we_n)); // R6

  AST_DRIVE_AFTER_WE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> $past(!mem_we_n)); // R6

  AST_DRIVE_ENDS_WITH_WE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> !mem_dq_oe); // R6

  AST_READ_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_we_n && !mem_ce_n)); // R2

  AST_WRITE_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_oe_n && !mem_ce_n)); // R5

  AST_ADDR_STABLE_WE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && !$past(mem_we_n)) |-> $stable(mem_addr)); // R5

  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready); // R3

endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W        = 19,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned CLK_PERIOD_PS = 4000,
  parameter int unsigned T_ACCESS_PS   = 10000,
  parameter int unsigned T_FLOAT_PS    = 5000,
  parameter int unsigned T_WPULSE_PS   = 7000,
  parameter int unsigned T_DSETUP_PS   = 5000,
  parameter int unsigned T_WCYCLE_PS   = 10000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);

  localparam int unsigned RD_CYC  = ceil_cyc(T_ACCESS_PS, CLK_PERIOD_PS);
  localparam int unsigned SU_CYC  = ceil_cyc(T_FLOAT_PS, CLK_PERIOD_PS);
  localparam int unsigned DS_CYC  = ceil_cyc(T_DSETUP_PS, CLK_PERIOD_PS);
  localparam int unsigned WP_CYC  = max_u(ceil_cyc(T_WPULSE_PS, CLK_PERIOD_PS), DS_CYC + 1);
  localparam int unsigned WC_CYC  = ceil_cyc(T_WCYCLE_PS, CLK_PERIOD_PS);
  localparam int unsigned REC_CYC = (WC_CYC > SU_CYC + WP_CYC) ? (WC_CYC - SU_CYC - WP_CYC) : 1;

  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  seq_state_e state_q, state_d;
  logic       accept, finish;

  sram_seq_fsm #(
    .RD_CYC (RD_CYC),
    .SU_CYC (SU_CYC),
    .WP_CYC (WP_CYC),
    .REC_CYC(REC_CYC)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .req_valid(req_valid),
    .req_write(req_write),
    .state_q  (state_q),
    .state_d  (state_d),
    .accept   (accept),
    .finish   (finish)
  );

  sram_pin_regs #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_pins (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .state_q  (state_q),
    .state_d  (state_d),
    .accept   (accept),
    .finish   (finish),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .mem_dq_i (mem_dq_i),
    .mem_addr (mem_addr),
    .mem_ce_n (mem_ce_n),
    .mem_oe_n (mem_oe_n),
    .mem_we_n (mem_we_n),
    .mem_dq_o (mem_dq_o),
    .mem_dq_oe(mem_dq_oe),
    .rsp_rdata(rsp_rdata),
    .req_ready(req_ready)
  );

endmodule

// File: tb/sram_strobe_ctrl_test.sv
`timescale 1ns/1ps
module sram_strobe_ctrl_test;

  localparam real CLK_PERIOD = 4.0;
  localparam int  CLK_PS     = 4000;
  localparam int  AW = 19;
  localparam int  DW = 8;

  function automatic int cdiv(input int t, input int c);
    int r;
    r = (t + c - 1) / c;
    return (r < 1) ? 1 : r;
  endfunction

  localparam int RD_E  = cdiv(10000, CLK_PS);
  localparam int SU_E  = cdiv(5000, CLK_PS);
  localparam int DS_E  = cdiv(5000, CLK_PS);
  localparam int WP_E  = (cdiv(7000, CLK_PS) > DS_E + 1) ? cdiv(7000, CLK_PS) : DS_E + 1;
  localparam int WC_E  = cdiv(10000, CLK_PS);
  localparam int REC_E = (WC_E > SU_E + WP_E) ? WC_E - SU_E - WP_E : 1;
  localparam int OE_ACC = cdiv(5000, CLK_PS);
  localparam int RD_LAT = 1 + RD_E;
  localparam int WR_LAT = SU_E + WP_E + REC_E;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_write;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic req_ready;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] mem_addr;
  logic mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [DW-1:0] mem_dq_o;
  logic [DW-1:0] mem_dq_i;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_strobe_ctrl #(.CLK_PERIOD_PS(CLK_PS)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
    .mem_dq_i(mem_dq_i)
  );

  // ---------------- behavioural memory model ----------------
  logic [7:0] model_mem [int unsigned];
  int oe_cnt = 0;
  int we_run = 0, dq_run = 0;
  int last_we_len = 0, last_dq_len = 0;
  int contention = 0, addr_moved = 0, stray_drive = 0, write_count = 0;
  logic prev_we_low = 1'b0;
  logic [AW-1:0] prev_addr = '0;
  logic dq_seen = 1'b0;
  logic [AW-1:0] wr_a = '0;
  logic [DW-1:0] wr_d = '0;

  initial mem_dq_i = 8'hEE;

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_dq_oe && !mem_oe_n) contention++;
      if (mem_dq_oe && mem_we_n) stray_drive++;
      if (!mem_we_n && prev_we_low && mem_addr != prev_addr) addr_moved++;
      if (!mem_we_n) begin
        we_run++;
        if (mem_dq_oe) begin
          dq_run++;
          dq_seen = 1'b1;
          wr_a = mem_addr;
          wr_d = mem_dq_o;
        end
      end else if (prev_we_low) begin
        last_we_len = we_run;
        last_dq_len = dq_run;
        if (dq_seen) begin
          model_mem[wr_a] = wr_d;
          write_count++;
        end
        we_run = 0; dq_run = 0; dq_seen = 1'b0;
      end
      if (!mem_ce_n && !mem_oe_n && mem_we_n) begin
        oe_cnt++;
        if (oe_cnt >= OE_ACC)
          mem_dq_i = model_mem.exists(mem_addr) ? model_mem[mem_addr] : 8'h00;
        else
          mem_dq_i = 8'hEE;
      end else begin
        oe_cnt = 0;
        mem_dq_i = 8'hEE;
      end
      prev_we_low = !mem_we_n;
      prev_addr   = mem_addr;
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int a);
    return DW'((a * 29 + 7) ^ (a >> 5) ^ (a >> 13));
  endfunction

  task automatic do_req(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        output int lat, output logic [DW-1:0] rd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    while (!req_ready && lat < 60) begin
      @(posedge clk); lat++; @(negedge clk);
    end
    rd = rsp_rdata;
    @(posedge clk); @(negedge clk);
    check(!req_ready, wr ? "R7 ready one cycle" : "R3 ready one cycle", req_ready, 0);
  endtask

  int wlen_bad = 0;
  task automatic write_chk(input logic [AW-1:0] a, input logic [DW-1:0] d);
    int lat; logic [DW-1:0] rd;
    do_req(1'b1, a, d, lat, rd);
    check(lat == WR_LAT, "R7 write latency", lat, WR_LAT);
    if (last_we_len != WP_E || last_dq_len != WP_E - 1) wlen_bad++;
  endtask

  task automatic read_chk(input logic [AW-1:0] a, input logic [DW-1:0] exp);
    int lat; logic [DW-1:0] rd;
    do_req(1'b0, a, 8'h00, lat, rd);
    check(lat == RD_LAT, "R3 read latency", lat, RD_LAT);
    check(rd == exp, "R4 R9 read data", rd, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++; n_checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    int lat; logic [DW-1:0] rd; int readies;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    check(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !req_ready,
          "R1 in reset", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, req_ready}, 5'b11100);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !req_ready,
          "R1 after release", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, req_ready}, 5'b11100);

    // R2: strobes in the read wait phase at a fixed point
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 19'h2A5A5;
    @(posedge clk); @(negedge clk); req_valid = 1'b0;
    check(!mem_ce_n && mem_oe_n && mem_we_n && mem_addr == 19'h2A5A5, "R2 read setup",
          {mem_ce_n, mem_oe_n, mem_we_n}, 3'b011);
    @(posedge clk); @(negedge clk);
    check(!mem_ce_n && !mem_oe_n && mem_we_n && !mem_dq_oe && mem_addr == 19'h2A5A5,
          "R2 read wait", {mem_ce_n, mem_oe_n, mem_we_n}, 3'b001);
    while (!req_ready) @(negedge clk);
    @(negedge clk);

    // R9: walking ones, extremes and a contiguous run, written then read
    write_chk('0, pat(0));
    write_chk(19'h7FFFF, pat(19'h7FFFF));
    for (int b = 0; b < AW; b++) write_chk(AW'(1) << b, pat(1 << b));
    for (int a = 100; a < 132; a++) write_chk(AW'(a), pat(a));
    check(wlen_bad == 0, "R5 R6 write pulse and drive window", wlen_bad, 0);

    read_chk('0, pat(0));
    read_chk(19'h7FFFF, pat(19'h7FFFF));
    for (int b = 0; b < AW; b++) read_chk(AW'(1) << b, pat(1 << b));
    for (int a = 100; a < 132; a++) read_chk(AW'(a), pat(a));

    // R8: hold a second write request during a busy write
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 19'h00055; req_wdata = 8'h3C;
    @(posedge clk); @(negedge clk);
    req_addr = 19'd101; req_wdata = 8'hC3;
    readies = 0;
    for (int i = 0; i < WR_LAT - 2; i++) begin
      @(posedge clk); @(negedge clk);
      if (req_ready) readies++;
    end
    req_valid = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(posedge clk); @(negedge clk);
      if (req_ready) readies++;
    end
    check(readies == 1, "R8 single ready for held request", readies, 1);
    read_chk(19'd101, pat(101));
    read_chk(19'h00055, 8'h3C);

    check(contention == 0, "R6 no bus contention", contention, 0);
    check(stray_drive == 0, "R6 drive only under write strobe", stray_drive, 0);
    check(addr_moved == 0, "R5 address stable under write strobe", addr_moved, 0);
    check(write_count == 2 + AW + 32 + 1, "R8 R9 memory write count", write_count, 2 + AW + 33);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule